// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block sits beside an interrupt distributor's per-line state store. For every CPU target it finds the one interrupt that should be signalled next: the line that is eligible, steered to that target, and carries the numerically lowest priority value. Ties are broken in favour of the lower interrupt ID. Selection is purely a function of the state presented on the ports. It is evaluated on every clock, and the outcome is registered, so each target's result is one cycle behind its inputs.

Each line is steered to at most one target, using one of two methods. In directed mode, the line's 32-bit packed affinity must equal a target's affinity exactly. In any-target mode, the line goes to the lowest-indexed target that has declared itself willing to take such interrupts for the line's group. A line that finds no target is offered to nobody.

Top module: `hppi_select`

## Requirements
- R1: A line is eligible only when its pending bit is 1, its enable bit is 1, its active bit is 0, and its group is enabled. The group code is 0, 1 or 2, and it is enabled by bit 0, 1 or 2 of `grp_en` respectively. Group code 3 is never eligible.
- R2: Among the eligible lines routed to a target, the one with the lowest priority value is chosen. When two such lines have equal priority values, the lower line ID wins.
- R3: A target's outputs `hp_id`, `hp_prio` and `hp_grp` all describe the same chosen line, and they are valid together.
- R4: In directed mode (`line_any` = 0), a line is routed to a target when its `line_aff` equals that target's `tgt_aff` in all 32 bits. The value is packed as level 3 in bits 31:24, level 2 in 23:16, level 1 in 15:8 and level 0 in 7:0. If several targets match, the lowest-indexed one is used.
- R5: In any-target mode (`line_any` = 1), a line is routed to the lowest-indexed target whose `tgt_any_acc` bit for the line's group code is set.
- R6: A line that matches no target, whether by affinity or by acceptance, is never presented on any target's outputs.
- R7: The outputs seen after a rising clock edge reflect the inputs sampled at that edge. The latency is exactly one cycle.
- R8: A target with no eligible routed line shows `hp_valid` = 0, `hp_prio` = 0xFF, `hp_id` = 0 and `hp_grp` = 0.
- R9: A synchronous active-high `rst` drives every target to the empty state of R8.
- R10: Clearing a line's pending bit, or its enable bit, removes that line from the result produced at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pend | input | NUM_LINES | Per-line pending bits |
| line_en | input | NUM_LINES | Per-line enable bits |
| line_act | input | NUM_LINES | Per-line active bits |
| line_grp | input | NUM_LINES x 2 | Per-line group code |
| line_prio | input | NUM_LINES x 8 | Per-line priority value, lower is more urgent |
| line_any | input | NUM_LINES | Per-line routing mode: 1 = any accepting target, 0 = directed |
| line_aff | input | NUM_LINES x 32 | Per-line packed four-level target affinity |
| grp_en | input | 3 | Global enable for group codes 0, 1 and 2 |
| tgt_aff | input | NUM_TGTS x 32 | Affinity of each target |
| tgt_any_acc | input | NUM_TGTS x 3 | Per-target, per-group acceptance of any-target lines |
| hp_valid | output | NUM_TGTS | A chosen line exists for the target |
| hp_id | output | NUM_TGTS x ID_W | Chosen line ID |
| hp_prio | output | NUM_TGTS x 8 | Chosen priority, 0xFF when none |
| hp_grp | output | NUM_TGTS x 2 | Chosen line's group code |

## Verification
The hardest situation to reach is the boundary where routing and ranking interact. Here a more urgent line is kept away from a target only because its affinity bytes are permuted, or because a lower-indexed target refuses its group. A less urgent line then has to surface on the correct target. The directed stimulus builds these cases explicitly: it swaps affinity bytes, gives two targets the same affinity, and toggles acceptance bits while equal-priority lines sit on both sides of an ID. A long pseudo-random run then uses a handful of priority values and affinities drawn from the targets' own values, so that ties and cross-routing occur constantly.

// File: rtl/hppi_pkg.sv
`timescale 1ns/1ps
package hppi_pkg;

    localparam int PRIO_W = 8;
    localparam int AFF_W  = 32;
    localparam int GRP_W  = 2;
    localparam int NGRP   = 3;

    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    typedef enum logic [GRP_W-1:0] {
        GRP_SEC0 = 2'd0,
        GRP_NS1  = 2'd1,
        GRP_SEC1 = 2'd2,
        GRP_RSVD = 2'd3
    } grp_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [GRP_W-1:0]  grp;
    } sel_meta_t;

    // Look up a per-group flag; the reserved code never matches.
    function automatic logic grp_sel(input logic [NGRP-1:0] vec,
                                     input logic [GRP_W-1:0] g);
        case (grp_e'(g))
            GRP_SEC0: return vec[0];
            GRP_NS1:  return vec[1];
            GRP_SEC1: return vec[2];
            default:  return 1'b0;
        endcase
    endfunction

    // Strictly more urgent: a lower number wins, an equal one does not.
    function automatic logic prio_wins(input logic [PRIO_W-1:0] cand,
                                       input logic [PRIO_W-1:0] cur);
        return cand < cur;
    endfunction

endpackage

// File: rtl/hppi_elig.sv
`timescale 1ns/1ps
module hppi_elig
    import hppi_pkg::*;
#(
    parameter int NL = 16
) (
    input  logic [NL-1:0]            pend,
    input  logic [NL-1:0]            en,
    input  logic [NL-1:0]            act,
    input  logic [NL-1:0][GRP_W-1:0] grp,
    input  logic [NGRP-1:0]          grp_en,
    output logic [NL-1:0]            elig
);
    for (genvar l = 0; l < NL; l++) begin : g_line
        assign elig[l] = pend[l] & en[l] & ~act[l] & grp_sel(grp_en, grp[l]);
    end
endmodule

// File: rtl/hppi_route.sv
`timescale 1ns/1ps
module hppi_route
    import hppi_pkg::*;
#(
    parameter int NL = 16,
    parameter int NT = 2
) (
    input  logic [NL-1:0]              line_any,
    input  logic [NL-1:0][GRP_W-1:0]   line_grp,
    input  logic [NL-1:0][AFF_W-1:0]   line_aff,
    input  logic [NT-1:0][AFF_W-1:0]   tgt_aff,
    input  logic [NT-1:0][NGRP-1:0]    tgt_acc,
    output logic [NL-1:0][NT-1:0]      route_oh
);
    for (genvar l = 0; l < NL; l++) begin : g_line
        logic [NT-1:0] hit;
        always_comb begin
            for (int t = 0; t < NT; t++) begin
                if (line_any[l])
                    hit[t] = grp_sel(tgt_acc[t], line_grp[l]);
                else
                    hit[t] = (line_aff[l] == tgt_aff[t]);
            end
        end
        // keep only the lowest-indexed matching target
        assign route_oh[l] = hit & (~hit + NT'(1));
    end
endmodule

// File: rtl/hppi_pick.sv
`timescale 1ns/1ps
module hppi_pick
    import hppi_pkg::*;
#(
    parameter int NL   = 16,
    parameter int ID_W = 4
) (
    input  logic [NL-1:0]             cand,
    input  logic [NL-1:0][PRIO_W-1:0] prio,
    input  logic [NL-1:0][GRP_W-1:0]  grp,
    output sel_meta_t                 meta,
    output logic [ID_W-1:0]           id
);
    // Ascending scan with a strict compare, so the lower ID keeps a tie.
    always_comb begin
        meta = '{valid: 1'b0, prio: PRIO_IDLE, grp: '0};
        id   = '0;
        for (int l = 0; l < NL; l++) begin
            if (cand[l] && (!meta.valid || prio_wins(prio[l], meta.prio))) begin
                meta.valid = 1'b1;
                meta.prio  = prio[l];
                meta.grp   = grp[l];
                id         = ID_W'(l);
            end
        end
    end
endmodule

// File: rtl/hppi_select.sv
`timescale 1ns/1ps
module hppi_select
    import hppi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_TGTS  = 2,
    localparam int ID_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_LINES-1:0]                line_pend,
    input  logic [NUM_LINES-1:0]                line_en,
    input  logic [NUM_LINES-1:0]                line_act,
    input  logic [NUM_LINES-1:0][GRP_W-1:0]     line_grp,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0]    line_prio,
    input  logic [NUM_LINES-1:0]                line_any,
    input  logic [NUM_LINES-1:0][AFF_W-1:0]     line_aff,
    input  logic [NGRP-1:0]                     grp_en,
    input  logic [NUM_TGTS-1:0][AFF_W-1:0]      tgt_aff,
    input  logic [NUM_TGTS-1:0][NGRP-1:0]       tgt_any_acc,
    output logic [NUM_TGTS-1:0]                 hp_valid,
    output logic [NUM_TGTS-1:0][ID_W-1:0]       hp_id,
    output logic [NUM_TGTS-1:0][PRIO_W-1:0]     hp_prio,
    output logic [NUM_TGTS-1:0][GRP_W-1:0]      hp_grp
);
    logic [NUM_LINES-1:0]                elig;
    logic [NUM_LINES-1:0][NUM_TGTS-1:0]  route_oh;
    logic [NUM_TGTS-1:0][NUM_LINES-1:0]  cmask;
    sel_meta_t [NUM_TGTS-1:0]            nxt_meta;
    logic [NUM_TGTS-1:0][ID_W-1:0]       nxt_id;

    hppi_elig #(.NL(NUM_LINES)) u_elig (
        .pend   (line_pend),
        .en     (line_en),
        .act    (line_act),
        .grp    (line_grp),
        .grp_en (grp_en),
        .elig   (elig)
    );

    hppi_route #(.NL(NUM_LINES), .NT(NUM_TGTS)) u_route (
        .line_any (line_any),
        .line_grp (line_grp),
        .line_aff (line_aff),
        .tgt_aff  (tgt_aff),
        .tgt_acc  (tgt_any_acc),
        .route_oh (route_oh)
    );

    for (genvar t = 0; t < NUM_TGTS; t++) begin : g_tgt
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_mask
            assign cmask[t][l] = elig[l] & route_oh[l][t];
        end

        hppi_pick #(.NL(NUM_LINES), .ID_W(ID_W)) u_pick (
            .cand (cmask[t]),
            .prio (line_prio),
            .grp  (line_grp),
            .meta (nxt_meta[t]),
            .id   (nxt_id[t])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                hp_valid[t] <= 1'b0;
                hp_id[t]    <= '0;
                hp_prio[t]  <= PRIO_IDLE;
                hp_grp[t]   <= '0;
            end else begin
                hp_valid[t] <= nxt_meta[t].valid;
                hp_id[t]    <= nxt_id[t];
                hp_prio[t]  <= nxt_meta[t].prio;
                hp_grp[t]   <= nxt_meta[t].grp;
            end
        end
    end

    // ---------------- assertions ----------------
    // Snapshots of the inputs and of the intermediate masks from the same edge
    // that loaded the outputs.
    logic [NUM_LINES-1:0]               pend_q, en_q, act_q;
    logic [NUM_LINES-1:0][GRP_W-1:0]    grp_q;
    logic [NUM_LINES-1:0][PRIO_W-1:0]   prio_q;
    logic [NGRP-1:0]                    gen_q;
    logic [NUM_LINES-1:0][NUM_TGTS-1:0] route_q;
    logic [NUM_TGTS-1:0][NUM_LINES-1:0] cmask_q;

    always_ff @(posedge clk) begin
        pend_q  <= line_pend;
        en_q    <= line_en;
        act_q   <= line_act;
        grp_q   <= line_grp;
        prio_q  <= line_prio;
        gen_q   <= grp_en;
        route_q <= route_oh;
        if (rst) cmask_q <= '0;
        else     cmask_q <= cmask;
    end

    for (genvar t = 0; t < NUM_TGTS; t++) begin : g_chk
        p_cand_rule_r1: assert property (@(posedge clk) disable iff (rst)
            hp_valid[t] |-> (pend_q[hp_id[t]] && en_q[hp_id[t]] && !act_q[hp_id[t]]
                             && grp_sel(gen_q, grp_q[hp_id[t]])));

        p_fields_r3: assert property (@(posedge clk) disable iff (rst)
            hp_valid[t] |-> (hp_prio[t] == prio_q[hp_id[t]] && hp_grp[t] == grp_q[hp_id[t]]));

        p_routed_r6: assert property (@(posedge clk) disable iff (rst)
            hp_valid[t] |-> route_q[hp_id[t]][t]);

        p_empty_r8: assert property (@(posedge clk) disable iff (rst)
            (cmask_q[t] == '0) |-> (!hp_valid[t] && hp_prio[t] == PRIO_IDLE));

        for (genvar l = 0; l < NUM_LINES; l++) begin : g_best
            p_best_r2: assert property (@(posedge clk) disable iff (rst)
                cmask_q[t][l] |-> (hp_valid[t] &&
                    (hp_prio[t] < prio_q[l] ||
                     (hp_prio[t] == prio_q[l] && hp_id[t] <= ID_W'(l)))));
        end
    end
endmodule

// File: tb/hppi_select_tb.sv
`timescale 1ns/1ps
module hppi_select_tb_top;
    import hppi_pkg::*;

    localparam int NL   = 16;
    localparam int NT   = 2;
    localparam int ID_W = 4;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NL-1:0]              line_pend = '0, line_en = '0, line_act = '0, line_any = '0;
    logic [NL-1:0][GRP_W-1:0]   line_grp = '0;
    logic [NL-1:0][PRIO_W-1:0]  line_prio = '0;
    logic [NL-1:0][AFF_W-1:0]   line_aff = '0;
    logic [NGRP-1:0]            grp_en = '0;
    logic [NT-1:0][AFF_W-1:0]   tgt_aff = '0;
    logic [NT-1:0][NGRP-1:0]    tgt_any_acc = '0;
    logic [NT-1:0]              hp_valid;
    logic [NT-1:0][ID_W-1:0]    hp_id;
    logic [NT-1:0][PRIO_W-1:0]  hp_prio;
    logic [NT-1:0][GRP_W-1:0]   hp_grp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] rs = 32'h1234_5678;

    typedef struct {
        int              tgt;
        logic            v;
        logic [ID_W-1:0] id;
        logic [7:0]      pr;
        logic [1:0]      g;
        string           tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    hppi_select #(.NUM_LINES(NL), .NUM_TGTS(NT)) dut_i (
        .clk(clk), .rst(rst),
        .line_pend(line_pend), .line_en(line_en), .line_act(line_act),
        .line_grp(line_grp), .line_prio(line_prio), .line_any(line_any),
        .line_aff(line_aff), .grp_en(grp_en), .tgt_aff(tgt_aff),
        .tgt_any_acc(tgt_any_acc),
        .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio), .hp_grp(hp_grp)
    );

    function automatic logic [31:0] nxt_rand();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic bit grp_on(input logic [2:0] v, input logic [1:0] g);
        return (g != 2'd3) && v[g];
    endfunction

    function automatic int dest_of(input int l);
        for (int t = 0; t < NT; t++) begin
            if (line_any[l] ? grp_on(tgt_any_acc[t], line_grp[l]) : (line_aff[l] == tgt_aff[t]))
                return t;
        end
        return -1;
    endfunction

    // Reference model: push the expected result of the current inputs.
    task automatic drive(input string tag);
        for (int t = 0; t < NT; t++) begin
            exp_t e;
            e.tgt = t; e.v = 1'b0; e.id = '0; e.pr = 8'hFF; e.g = '0; e.tag = tag;
            for (int l = 0; l < NL; l++) begin
                if (line_pend[l] && line_en[l] && !line_act[l] && grp_on(grp_en, line_grp[l])
                    && dest_of(l) == t && (!e.v || line_prio[l] < e.pr)) begin
                    e.v = 1'b1; e.id = ID_W'(l); e.pr = line_prio[l]; e.g = line_grp[l];
                end
            end
            sb_q.push_back(e);
        end
        @(negedge clk);
    endtask

    // Monitor: compare one edge's worth of results just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (hp_valid[e.tgt] !== e.v || hp_id[e.tgt] !== e.id ||
                    hp_prio[e.tgt] !== e.pr || hp_grp[e.tgt] !== e.g) begin
                    n_bad++;
                    $display("FAIL %s tgt%0d: got v=%0b id=%0d pr=%02h g=%0d exp v=%0b id=%0d pr=%02h g=%0d",
                             e.tag, e.tgt, hp_valid[e.tgt], hp_id[e.tgt], hp_prio[e.tgt],
                             hp_grp[e.tgt], e.v, e.id, e.pr, e.g);
                end
            end
        end
    end

    task automatic clear_lines();
        line_pend = '0; line_en = '0; line_act = '0; line_any = '0;
        line_grp = '0; line_prio = '0; line_aff = '0; tgt_any_acc = '0;
        grp_en = 3'b111;
    endtask

    task automatic put(input int l, input logic [7:0] p, input logic [1:0] g, input logic [31:0] a);
        line_pend[l] = 1'b1; line_en[l] = 1'b1; line_act[l] = 1'b0;
        line_prio[l] = p; line_grp[l] = g; line_aff[l] = a; line_any[l] = 1'b0;
    endtask

    initial begin
        logic [31:0] t0a, t1a;
        t0a = {8'h00, 8'h00, 8'h00, 8'h01};
        t1a = {8'h01, 8'h02, 8'h03, 8'h04};
        tgt_aff[0] = t0a;
        tgt_aff[1] = t1a;
        line_pend = '1; line_en = '1; grp_en = 3'b111;
        line_aff = {NL{t0a}};
        repeat (3) @(negedge clk);
        // R9: reset state, with eligible lines present at the inputs
        for (int t = 0; t < NT; t++) begin
            n_cmp++;
            if (hp_valid[t] !== 1'b0 || hp_prio[t] !== 8'hFF || hp_id[t] !== '0 || hp_grp[t] !== '0) begin
                n_bad++;
                $display("FAIL R9 tgt%0d: got v=%0b pr=%02h id=%0d g=%0d exp v=0 pr=ff id=0 g=0",
                         t, hp_valid[t], hp_prio[t], hp_id[t], hp_grp[t]);
            end
        end
        rst = 1'b0;
        clear_lines();
        drive("R8");

        // R4: directed line to target 1
        put(5, 8'h40, 2'd1, t1a);             drive("R4");
        // R2: lower value wins
        put(9, 8'h20, 2'd2, t1a);             drive("R2");
        // R2: equal value, lower ID wins
        put(3, 8'h20, 2'd0, t1a);             drive("R2");
        // R3: lines on both targets with different groups
        put(12, 8'h10, 2'd2, t0a);            drive("R3");
        // R1: active line excluded
        line_act[3] = 1'b1;                   drive("R1");
        // R10: disabling drops the line at the next edge
        line_en[9] = 1'b0;                    drive("R10");
        // R1: group enable off
        grp_en = 3'b101;                      drive("R1");
        grp_en = 3'b111;
        // R10: pending cleared
        line_pend[12] = 1'b0;                 drive("R10");
        // R1: reserved group never eligible
        clear_lines();
        put(2, 8'h00, 2'd3, t0a);             drive("R1");
        // R4: byte-swapped affinity must not match (R6)
        clear_lines();
        put(4, 8'h08, 2'd0, {8'h04, 8'h03, 8'h02, 8'h01}); drive("R6");
        // R4: one differing level byte
        line_aff[4] = {8'h01, 8'h02, 8'h03, 8'h05};         drive("R4");
        // R4: two targets share an affinity, lowest index wins
        line_aff[4] = t1a; tgt_aff[0] = t1a;                drive("R4");
        tgt_aff[0] = t0a;
        // R5: any-target mode
        clear_lines();
        put(7, 8'h30, 2'd2, 32'hDEAD_BEEF); line_any[7] = 1'b1;
        tgt_any_acc[0] = 3'b001; tgt_any_acc[1] = 3'b100;   drive("R5");
        tgt_any_acc[0] = 3'b100;                            drive("R5");
        // R6: nobody accepts
        tgt_any_acc = '0;                                   drive("R6");
        // R7: back-to-back changes track one cycle behind
        put(1, 8'h05, 2'd1, t0a);                           drive("R7");
        line_prio[1] = 8'h50; put(6, 8'h50, 2'd1, t0a);     drive("R7");
        line_pend[1] = 1'b0;                                drive("R7");

        // R2: pseudo-random state with frequent ties and cross routing
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            for (int l = 0; l < NL; l++) begin
                r = nxt_rand();
                line_pend[l] = r[0] | r[1];
                line_en[l]   = r[2] | r[3];
                line_act[l]  = r[4] & r[5];
                line_grp[l]  = r[7:6];
                line_prio[l] = {r[9:8], 6'd0};
                line_any[l]  = r[10] & r[11];
                case (r[13:12])
                    2'd0:    line_aff[l] = t0a;
                    2'd1:    line_aff[l] = t1a;
                    2'd2:    line_aff[l] = t1a;
                    default: line_aff[l] = r ^ 32'h5A5A_0000;
                endcase
            end
            r = nxt_rand();
            grp_en = r[2:0] | {2'b00, r[3]};
            tgt_any_acc[0] = r[6:4];
            tgt_any_acc[1] = r[9:7];
            tgt_aff[0] = r[10] ? t1a : t0a;
            drive("R2");
        end
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule